// File: doc/BRIEF.md
# Privileged-Mode Trap Dispatch Controller

This block sits beside a processor's fetch and issue logic and owns every transition into and out of privileged mode. Privileged mode is not a separate flag: it is bit 0 of the program counter, and the `in_pal` output simply reports that bit. A trap request carries a trap class and the faulting PC. A privileged-call request carries an 8-bit function code and the address of the following instruction. Both requests enter privileged mode at an address built from the privileged base register. On entry the block saves a return address, raises the interrupt priority level to 7, forces kernel mode and enables the shadow registers.

Two exit paths exist. The hardware return instruction jumps to a target taken from a register operand. A result commit lets a finished handler halt in place, re-enter at the restart vector, or return normally. Every accepted request completes in one clock. The block pulses a one-cycle pipeline flush whenever it redirects the PC. A handler may also load the interrupt priority level and current mode directly. The decoder, the register file and the handlers themselves live elsewhere.

Top module: `pal_dispatch_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `pc` = 0x8001, `exc_addr` = 0, `ipl` = 7, `cur_mode` = 0 (kernel), `shadow_en` = 0 and `flush` = 0.
- R2: A trap enters at ({pal_base[63:15], 15'b0}) | (offset & 0x7FFE) | 1. The trap_class encoding and offsets are: 0 illegal instruction 0x480, 1 privileged violation 0x480, 2 arithmetic 0x500, 3 instruction-translation fault 0x300, 4 data-translation fault 0x400, 5 unaligned 0x600, 6 machine check 0x660, 7 interrupt 0x680. With pal_base = 0x600000, an illegal-instruction trap enters at 0x600481.
- R3: A legal privileged call enters at {pal_base[63:15], 15'b0} | (1<<13) | (func[7]<<12) | (func[5:0]<<6) | 1.
- R4: Function codes 0x40–0x7F and 0xC0–0xFF are illegal and enter at the illegal-instruction vector, {pal_base[63:15], 15'b0} | 0x481.
- R5: On any entry, `exc_addr` takes `trap_pc` for a trap or `cpal_next_pc` for a call. Also on entry, `pc` bit 0 becomes 1, `ipl` becomes 7, `cur_mode` becomes 0 and `shadow_en` becomes 1, all in the same cycle.
- R6: If pal_base[63:15] is zero, an entry escalates to the machine-check vector, and `pc` becomes 0x661 for traps and calls alike.
- R7: A hardware return loads `pc` with `hwret_target` with bit 0 cleared and clears `shadow_en`. It leaves `exc_addr`, `ipl` and `cur_mode` unchanged.
- R8: A commit with `commit_halt` = 1 loads `pc[63:1]` from `commit_pc` and keeps the current `pc[0]`, leaving every other state unchanged. Halt wins over restart.
- R9: A commit with `commit_restart` = 1 and no halt sets `pc` to {pal_base[63:15], 15'b0} | 1 and leaves every other state unchanged.
- R10: A commit with neither flag loads `pc` with `commit_pc` with bit 0 cleared and clears `shadow_en`.
- R11: Requests arriving in the same cycle are served in the order trap, call, hardware return, commit, mode/level write. Lower-priority requests in that cycle are ignored. With no request, all state holds.
- R12: `flush` is 1 for exactly the one cycle after an accepted trap, call, hardware return or commit, and 0 otherwise.
- R13: An accepted `ps_wr` loads `ipl` from `ps_ipl` and `cur_mode` from `ps_mode`. `in_pal` always equals `pc[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_base | input | 64 | Privileged base register |
| trap_req | input | 1 | Trap request |
| trap_class | input | 3 | Trap class code |
| trap_pc | input | 64 | Faulting instruction PC |
| cpal_req | input | 1 | Privileged-call request |
| cpal_func | input | 8 | Call function code |
| cpal_next_pc | input | 64 | Address after the call instruction |
| hwret_req | input | 1 | Hardware return request |
| hwret_target | input | 64 | Register-supplied return target |
| commit_req | input | 1 | Result commit that modifies the PC |
| commit_halt | input | 1 | Halt flag of the commit |
| commit_restart | input | 1 | Restart flag of the commit |
| commit_pc | input | 64 | New PC of the commit |
| ps_wr | input | 1 | Load of level and mode |
| ps_ipl | input | 5 | Level to load |
| ps_mode | input | 2 | Mode to load |
| pc | output | 64 | Program counter, bit 0 = privileged |
| in_pal | output | 1 | Privileged-mode query |
| exc_addr | output | 64 | Saved return/retry address |
| ipl | output | 5 | Interrupt priority level |
| cur_mode | output | 2 | Current mode, 0 = kernel |
| shadow_en | output | 1 | Shadow register enable |
| flush | output | 1 | One-cycle pipeline flush |

## Verification
The collision that matters most is a trap and a privileged call landing in the same cycle. If the call won, `exc_addr` would hold the call's next PC and the entry address would have bit 13 set. The random stimulus raises each request independently at about one chance in three, so these collisions occur often. A directed cycle also raises all five requests together. The bench model serves requests in the required order, and every field is compared after each cycle, so a wrong winner shows in `pc`, `exc_addr` or `shadow_en`.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int VEC_W = 15;

  typedef enum logic [2:0] {
    TC_ILLEGAL = 3'd0,
    TC_PRIV    = 3'd1,
    TC_ARITH   = 3'd2,
    TC_ITRANS  = 3'd3,
    TC_DTRANS  = 3'd4,
    TC_UNALIGN = 3'd5,
    TC_MCHECK  = 3'd6,
    TC_INTR    = 3'd7
  } trap_class_e;

  localparam logic [VEC_W-1:0] OFF_OPCDEC = 15'h0480;
  localparam logic [VEC_W-1:0] OFF_MCHK   = 15'h0660;
  localparam logic [VEC_W-1:0] OFF_RESET  = 15'h0000;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  // Request slots, highest priority first.
  localparam int G_TRAP   = 0;
  localparam int G_CPAL   = 1;
  localparam int G_HWRET  = 2;
  localparam int G_COMMIT = 3;
  localparam int G_PS     = 4;
  localparam int N_REQ    = 5;

  function automatic logic [VEC_W-1:0] trap_vec_off(input trap_class_e c);
    logic [VEC_W-1:0] o;
    unique case (c)
      TC_ILLEGAL, TC_PRIV: o = OFF_OPCDEC;
      TC_ARITH:            o = 15'h0500;
      TC_ITRANS:           o = 15'h0300;
      TC_DTRANS:           o = 15'h0400;
      TC_UNALIGN:          o = 15'h0600;
      TC_MCHECK:           o = OFF_MCHK;
      default:             o = 15'h0680;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pal_req_arb.sv
module pal_req_arb #(
  parameter int NREQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);

  for (genvar i = 0; i < NREQ; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R11
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (gnt == '0)); // R11

endmodule

// File: rtl/pal_vector_gen.sv
module pal_vector_gen
  import pal_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pal_base,
  input  trap_class_e     trap_class,
  input  logic [7:0]      cpal_func,
  output logic [PC_W-1:0] trap_entry,
  output logic [PC_W-1:0] cpal_entry,
  output logic [PC_W-1:0] restart_pc,
  output logic            cpal_illegal
);

  localparam logic [PC_W-1:0] LOW_MASK  = PC_W'({VEC_W{1'b1}});
  localparam logic [PC_W-1:0] BASE_MASK = ~LOW_MASK;
  localparam logic [PC_W-1:0] MCHK_PC   = PC_W'({OFF_MCHK[VEC_W-1:1], 1'b1});

  logic [PC_W-1:0]  base_hi;
  logic             base_zero;
  logic [VEC_W-1:0] exc_off;
  logic [VEC_W-1:0] trap_low;
  logic [VEC_W-1:0] cpal_low;

  assign base_hi   = pal_base & BASE_MASK;
  assign base_zero = (base_hi == '0);
  assign exc_off   = trap_vec_off(trap_class);

  // Codes 0x40-0x7F and 0xC0-0xFF both have bit 6 set.
  assign cpal_illegal = cpal_func[6];

  always_comb begin
    trap_low = {exc_off[VEC_W-1:1], 1'b1};
    if (cpal_illegal) begin
      cpal_low = {OFF_OPCDEC[VEC_W-1:1], 1'b1};
    end else begin
      cpal_low = {1'b0, 1'b1, cpal_func[7], cpal_func[5:0], 5'b0, 1'b1};
    end
  end

  assign trap_entry = base_zero ? MCHK_PC : (base_hi | PC_W'(trap_low));
  assign cpal_entry = base_zero ? MCHK_PC : (base_hi | PC_W'(cpal_low));
  assign restart_pc = base_hi | PC_W'({OFF_RESET[VEC_W-1:1], 1'b1});

  AST_CPAL_BIT13: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_zero && !cpal_func[6]) |-> (cpal_entry[13] && cpal_entry[0]
      && cpal_entry[PC_W-1:VEC_W] == pal_base[PC_W-1:VEC_W])); // R3
  AST_ILLEGAL_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_zero && cpal_func[6]) |-> (cpal_entry[VEC_W-1:0] == 15'h0481)); // R4
  AST_ZERO_BASE_MCHK: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_base[PC_W-1:VEC_W] == '0) |-> (trap_entry == PC_W'(16'h0661)
      && cpal_entry == PC_W'(16'h0661))); // R6
  AST_TRAP_NO_BIT13: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_entry[13] && trap_entry[0]); // R2

endmodule

// File: rtl/pal_dispatch_ctrl.sv
module pal_dispatch_ctrl
  import pal_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int IPL_W  = 5,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pal_base,
  input  logic              trap_req,
  input  logic [2:0]        trap_class,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic              cpal_req,
  input  logic [7:0]        cpal_func,
  input  logic [PC_W-1:0]   cpal_next_pc,
  input  logic              hwret_req,
  input  logic [PC_W-1:0]   hwret_target,
  input  logic              commit_req,
  input  logic              commit_halt,
  input  logic              commit_restart,
  input  logic [PC_W-1:0]   commit_pc,
  input  logic              ps_wr,
  input  logic [IPL_W-1:0]  ps_ipl,
  input  logic [MODE_W-1:0] ps_mode,
  output logic [PC_W-1:0]   pc,
  output logic              in_pal,
  output logic [PC_W-1:0]   exc_addr,
  output logic [IPL_W-1:0]  ipl,
  output logic [MODE_W-1:0] cur_mode,
  output logic              shadow_en,
  output logic              flush
);

  localparam logic [PC_W-1:0]   RESET_PC  = PC_W'(32'h0000_8001);
  localparam logic [PC_W-1:0]   BIT0_MASK = PC_W'(1);
  localparam logic [IPL_W-1:0]  IPL_MAX   = IPL_W'(7);
  localparam logic [MODE_W-1:0] KERNEL    = MODE_W'(MODE_KERNEL);

  logic [N_REQ-1:0] req, gnt;
  logic [PC_W-1:0]  trap_entry, cpal_entry, restart_pc;
  logic             cpal_illegal;

  logic [PC_W-1:0]   pc_q, pc_d;
  logic [PC_W-1:0]   exc_q, exc_d;
  logic [IPL_W-1:0]  ipl_q, ipl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              shadow_q, shadow_d;
  logic              flush_q, flush_d;
  logic              state_en;

  assign req[G_TRAP]   = trap_req;
  assign req[G_CPAL]   = cpal_req;
  assign req[G_HWRET]  = hwret_req;
  assign req[G_COMMIT] = commit_req;
  assign req[G_PS]     = ps_wr;

  pal_req_arb #(.NREQ(N_REQ)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .gnt  (gnt)
  );

  pal_vector_gen #(.PC_W(PC_W)) u_vec (
    .clk         (clk),
    .rst_n       (rst_n),
    .pal_base    (pal_base),
    .trap_class  (trap_class_e'(trap_class)),
    .cpal_func   (cpal_func),
    .trap_entry  (trap_entry),
    .cpal_entry  (cpal_entry),
    .restart_pc  (restart_pc),
    .cpal_illegal(cpal_illegal)
  );

  assign state_en = |gnt;

  // Next-state selection
  always_comb begin
    pc_d     = pc_q;
    exc_d    = exc_q;
    ipl_d    = ipl_q;
    mode_d   = mode_q;
    shadow_d = shadow_q;
    flush_d  = 1'b0;
    if (gnt[G_TRAP] || gnt[G_CPAL]) begin
      exc_d    = gnt[G_TRAP] ? trap_pc : cpal_next_pc;
      pc_d     = gnt[G_TRAP] ? trap_entry : cpal_entry;
      ipl_d    = IPL_MAX;
      mode_d   = KERNEL;
      shadow_d = 1'b1;
      flush_d  = 1'b1;
    end else if (gnt[G_HWRET]) begin
      pc_d     = hwret_target & ~BIT0_MASK;
      shadow_d = 1'b0;
      flush_d  = 1'b1;
    end else if (gnt[G_COMMIT]) begin
      flush_d = 1'b1;
      if (commit_halt) begin
        pc_d = (commit_pc & ~BIT0_MASK) | (pc_q & BIT0_MASK);
      end else if (commit_restart) begin
        pc_d = restart_pc;
      end else begin
        pc_d     = commit_pc & ~BIT0_MASK;
        shadow_d = 1'b0;
      end
    end else if (gnt[G_PS]) begin
      ipl_d  = ps_ipl;
      mode_d = ps_mode;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      exc_q    <= '0;
      ipl_q    <= IPL_MAX;
      mode_q   <= KERNEL;
      shadow_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= flush_d;
      if (state_en) begin
        pc_q     <= pc_d;
        exc_q    <= exc_d;
        ipl_q    <= ipl_d;
        mode_q   <= mode_d;
        shadow_q <= shadow_d;
      end
    end
  end

  assign pc        = pc_q;
  assign in_pal    = pc_q[0];
  assign exc_addr  = exc_q;
  assign ipl       = ipl_q;
  assign cur_mode  = mode_q;
  assign shadow_en = shadow_q;
  assign flush     = flush_q;

  AST_ENTRY_PAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[G_TRAP] || gnt[G_CPAL]) |=> pc_q[0]); // R5
  AST_ENTRY_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[G_TRAP] || gnt[G_CPAL]) |=> (ipl_q == IPL_MAX && mode_q == KERNEL
      && shadow_q)); // R5
  AST_TRAP_RETRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[G_TRAP] |=> (exc_q == $past(trap_pc))); // R5
  AST_HWRET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[G_HWRET] |=> (!pc_q[0] && !shadow_q && $stable(exc_q))); // R7
  AST_HALT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[G_COMMIT] && commit_halt) |=> ($stable(pc_q[0]) && $stable(shadow_q))); // R8
  AST_NORMAL_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[G_COMMIT] && !commit_halt && !commit_restart) |=> (!pc_q[0] && !shadow_q)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> ($stable(pc_q) && $stable(exc_q) && $stable(ipl_q))); // R11
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(|gnt[G_COMMIT:G_TRAP])); // R12
  AST_FLUSH_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt[G_COMMIT:G_TRAP]) |=> flush_q); // R12

endmodule

// File: tb/tb_pal_dispatch_ctrl.sv
module tb_pal_dispatch_ctrl;

  localparam int PC_W = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [63:0]     pal_base;
  logic            trap_req;
  logic [2:0]      trap_class;
  logic [63:0]     trap_pc;
  logic            cpal_req;
  logic [7:0]      cpal_func;
  logic [63:0]     cpal_next_pc;
  logic            hwret_req;
  logic [63:0]     hwret_target;
  logic            commit_req, commit_halt, commit_restart;
  logic [63:0]     commit_pc;
  logic            ps_wr;
  logic [4:0]      ps_ipl;
  logic [1:0]      ps_mode;
  logic [63:0]     pc, exc_addr;
  logic            in_pal, shadow_en, flush;
  logic [4:0]      ipl;
  logic [1:0]      cur_mode;

  // Model state
  logic [63:0] m_pc, m_exc;
  logic [4:0]  m_ipl;
  logic [1:0]  m_mode;
  logic        m_shadow, m_flush;
  string       m_tag;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;

  always #5 clk = ~clk;

  pal_dispatch_ctrl #(.PC_W(PC_W)) dut (.*);

  function automatic logic [63:0] base_hi(input logic [63:0] b);
    return b & ~64'h7FFF;
  endfunction

  function automatic logic [63:0] exp_trap(input logic [63:0] b, input logic [2:0] c);
    logic [63:0] off;
    case (c)
      3'd0, 3'd1: off = 64'h480;
      3'd2:       off = 64'h500;
      3'd3:       off = 64'h300;
      3'd4:       off = 64'h400;
      3'd5:       off = 64'h600;
      3'd6:       off = 64'h660;
      default:    off = 64'h680;
    endcase
    if (base_hi(b) == 0) return 64'h661;
    return base_hi(b) | (off & 64'h7FFE) | 64'h1;
  endfunction

  function automatic logic [63:0] exp_cpal(input logic [63:0] b, input logic [7:0] f);
    if (base_hi(b) == 0) return 64'h661;
    if ((f >= 8'h40 && f <= 8'h7F) || f > 8'hBF) return base_hi(b) | 64'h481;
    return base_hi(b) | 64'h2000 | (64'(f[7]) << 12) | (64'(f[5:0]) << 6) | 64'h1;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    trap_req = 0; cpal_req = 0; hwret_req = 0; commit_req = 0; ps_wr = 0;
    commit_halt = 0; commit_restart = 0;
  endtask

  // Advance the model by one accepted request, in priority order (R11).
  task automatic model_step();
    m_flush = 1'b0;
    if (trap_req || cpal_req) begin
      m_tag    = trap_req ? "R2/R5/R11" : "R3/R4/R5";
      m_exc    = trap_req ? trap_pc : cpal_next_pc;
      m_pc     = trap_req ? exp_trap(pal_base, trap_class) : exp_cpal(pal_base, cpal_func);
      m_ipl    = 5'd7;
      m_mode   = 2'd0;
      m_shadow = 1'b1;
      m_flush  = 1'b1;
    end else if (hwret_req) begin
      m_tag = "R7";
      m_pc = {hwret_target[63:1], 1'b0};
      m_shadow = 1'b0;
      m_flush = 1'b1;
    end else if (commit_req) begin
      m_flush = 1'b1;
      if (commit_halt) begin
        m_tag = "R8";
        m_pc = {commit_pc[63:1], m_pc[0]};
      end else if (commit_restart) begin
        m_tag = "R9";
        m_pc = base_hi(pal_base) | 64'h1;
      end else begin
        m_tag = "R10";
        m_pc = {commit_pc[63:1], 1'b0};
        m_shadow = 1'b0;
      end
    end else if (ps_wr) begin
      m_tag = "R13";
      m_ipl = ps_ipl;
      m_mode = ps_mode;
    end else begin
      m_tag = "R11/R12";
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "pc", pc, m_pc);
    chk(m_tag, "exc_addr", exc_addr, m_exc);
    chk(m_tag, "ipl", 64'(ipl), 64'(m_ipl));
    chk(m_tag, "cur_mode", 64'(cur_mode), 64'(m_mode));
    chk(m_tag, "shadow_en", 64'(shadow_en), 64'(m_shadow));
    chk("R12", "flush", 64'(flush), 64'(m_flush));
    chk("R13", "in_pal", 64'(in_pal), 64'(pc[0]));
  endtask

  // Inputs set by the caller after a falling edge; one clock; compare at the next falling edge.
  task automatic apply();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    clear_inputs();
  endtask

  task automatic randomize_inputs();
    pal_base = ($urandom_range(0, 7) == 0) ? 64'($urandom_range(0, 32'h7FFF))
                                            : {$urandom, $urandom};
    trap_req = ($urandom_range(0, 2) == 0);
    trap_class = 3'($urandom);
    trap_pc = {$urandom, $urandom};
    cpal_req = ($urandom_range(0, 2) == 0);
    cpal_func = 8'($urandom);
    cpal_next_pc = {$urandom, $urandom};
    hwret_req = ($urandom_range(0, 2) == 0);
    hwret_target = {$urandom, $urandom};
    commit_req = ($urandom_range(0, 2) == 0);
    commit_halt = ($urandom_range(0, 3) == 0);
    commit_restart = ($urandom_range(0, 2) == 0);
    commit_pc = {$urandom, $urandom};
    ps_wr = ($urandom_range(0, 2) == 0);
    ps_ipl = 5'($urandom);
    ps_mode = 2'($urandom);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    clear_inputs();
    pal_base = 64'h600000; trap_class = 0; trap_pc = 0; cpal_func = 0;
    cpal_next_pc = 0; hwret_target = 0; commit_pc = 0; ps_ipl = 0; ps_mode = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "pc", pc, 64'h8001);
    chk("R1", "exc_addr", exc_addr, 64'h0);
    chk("R1", "ipl", 64'(ipl), 64'd7);
    chk("R1", "shadow_en", 64'(shadow_en), 64'd0);
    chk("R1", "flush", 64'(flush), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after release", pc, 64'h8001);
    m_pc = 64'h8001; m_exc = 0; m_ipl = 7; m_mode = 0; m_shadow = 0; m_flush = 0;

    // R13: drop to a lower level and user mode first
    ps_wr = 1; ps_ipl = 5'd2; ps_mode = 2'd3; apply();

    // R2: illegal-instruction trap with base 0x600000
    pal_base = 64'h600000; trap_req = 1; trap_class = 3'd0; trap_pc = 64'h1234; apply();
    chk("R2", "illegal entry", pc, 64'h600481);
    chk("R5", "retry addr", exc_addr, 64'h1234);

    // R7: hardware return
    hwret_req = 1; hwret_target = 64'h6E1; apply();
    chk("R7", "hwret pc", pc, 64'h6E0);

    // R3: legal call 0x83
    cpal_req = 1; cpal_func = 8'h83; cpal_next_pc = 64'h6E4; apply();
    chk("R3", "call entry", pc, 64'h6030C1);

    // R4: illegal codes at both boundaries
    cpal_req = 1; cpal_func = 8'h40; apply();
    chk("R4", "code 0x40", pc, 64'h600481);
    cpal_req = 1; cpal_func = 8'hC0; apply();
    chk("R4", "code 0xC0", pc, 64'h600481);
    cpal_req = 1; cpal_func = 8'hBF; apply();
    chk("R3", "code 0xBF", pc, 64'h603FC1);

    // R8: halt keeps privileged bit, beats restart
    commit_req = 1; commit_halt = 1; commit_restart = 1; commit_pc = 64'h5C8; apply();
    chk("R8", "halt pc", pc, 64'h5C9);

    // R9: restart
    pal_base = 64'h600123; commit_req = 1; commit_restart = 1; apply();
    chk("R9", "restart pc", pc, 64'h600001);

    // R10: normal return
    commit_req = 1; commit_pc = 64'h78D; apply();
    chk("R10", "normal return pc", pc, 64'h78C);

    // R6: zero base escalates
    pal_base = 64'h7FFF; trap_req = 1; trap_class = 3'd2; apply();
    chk("R6", "zero base trap", pc, 64'h661);
    cpal_req = 1; cpal_func = 8'h83; apply();
    chk("R6", "zero base call", pc, 64'h661);

    // R11: all requests together; trap wins
    pal_base = 64'hA0000; trap_req = 1; trap_class = 3'd7; trap_pc = 64'h999;
    cpal_req = 1; cpal_func = 8'h02; cpal_next_pc = 64'h777;
    hwret_req = 1; commit_req = 1; ps_wr = 1; ps_ipl = 5'd1; apply();
    chk("R11", "trap beats call pc", pc, 64'hA0681);
    chk("R11", "trap beats call exc", exc_addr, 64'h999);

    // R12: idle cycle drops flush
    apply();
    chk("R12", "flush idle", 64'(flush), 64'd0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      apply();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule